// File: doc/BRIEF.md
# Edge-Triggered Manual Reset Pulse Generator

This block turns a push-button style manual reset pin into a clean reset pulse of fixed length. The pin's active polarity is chosen by a select input. Only the transition of the pin into its active state starts a pulse; a pin that sits at its active level does nothing more. Each pulse lasts a fixed number of clock cycles, set by a parameter. The default matches 200 ms at 50 MHz. The pulse ends when that count runs out, even if the pin is still held.

The pulse appears on a pair of complementary outputs, one active high and one active low. A third output blocks access to an attached memory. It is raised whenever any reset cause is present: power-on reset, a running pulse, or the pin still sitting at its active level after the pulse has ended. The pin is synchronized to the clock by a two-flop chain before any decision is made. While power-on reset is asserted, all outputs are held active and the edge detector is loaded with the pin's present level, so the release of power-on reset does not look like a pin edge.

Top module: `mrst_pulse_gen`

## Requirements
- R1: While `rst` is high, `rst_hi_o` is 1, `rst_lo_o` is 0 and `mem_inhibit_o` is 1.
- R2: After `rst` is released with the pin at its inactive level, all three outputs go inactive (`rst_hi_o`=0, `rst_lo_o`=1, `mem_inhibit_o`=0) from the first clock onward.
- R3: With `pol_low`=0, a 0-to-1 transition of `mr_pin` that is set up before clock edge N1 raises `rst_hi_o` after edge N1+2. It stays high for exactly `PULSE_CYCLES` cycles.
- R4: With `pol_low`=1, the active level is 0. A 1-to-0 transition of `mr_pin` starts the same pulse, with the same timing as R3.
- R5: A pin level alone never starts a pulse. Neither a pin already active when `rst` is released nor a return of the pin to its inactive level produces a pulse.
- R6: If the pin is held active longer than the pulse, `rst_hi_o` still falls after `PULSE_CYCLES` cycles.
- R7: `mem_inhibit_o` is 1 whenever `rst_hi_o` is 1 or the synchronized pin is at its active level. The pin level reaches this output after edge N1+1.
- R8: A new active transition while a pulse is running restarts the count, so the pulse ends `PULSE_CYCLES` cycles after the restart.
- R9: `rst_lo_o` is always the inverse of `rst_hi_o`.
- R10: An active pin pulse lasting only one clock cycle still yields a full-length pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mr_pin | input | 1 | Raw, asynchronous manual reset pin |
| pol_low | input | 1 | 0: pin active high; 1: pin active low (change only under `rst`) |
| rst_hi_o | output | 1 | Reset pulse, active high |
| rst_lo_o | output | 1 | Reset pulse, active low |
| mem_inhibit_o | output | 1 | Memory access block, high while any reset cause is present |

## Verification
A pin change is set up before edge N1. It passes two synchronizer flops and then the timer register, so the reset outputs respond after edge N1+2 and fall after edge N1+2+`PULSE_CYCLES`. The memory inhibit follows the pin level one edge earlier, after N1+1. The bench drives the pin on a falling clock edge and counts falling edges from that point. It samples exactly at the counts where each output must be unchanged and where it must have changed. This pins down both the latency and the pulse length to the cycle, including the restart case, where the expected fall moves to `PULSE_CYCLES` cycles after the second edge.

// File: rtl/mrst_pkg.sv
package mrst_pkg;

    typedef enum logic {
        POL_ACT_HIGH = 1'b0,
        POL_ACT_LOW  = 1'b1
    } pin_pol_e;

    typedef struct packed {
        logic level;   // pin at its active level (synchronized)
        logic fire;    // single-cycle active transition
    } trig_t;

    function automatic logic to_active(input logic raw, input pin_pol_e pol);
        return raw ^ logic'(pol);
    endfunction

endpackage

// File: rtl/mrst_sync.sv
module mrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // no reset: the chain keeps sampling during power-on reset so the
    // downstream detector can be primed with the true pin level
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mrst_edge.sv
module mrst_edge
    import mrst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_pin,
    input  pin_pol_e pol,
    output trig_t    trig
);
    logic act_now;
    logic act_prev;

    assign act_now = to_active(sync_pin, pol);

    always_ff @(posedge clk) begin
        // primed with the live level during reset: no false transition
        act_prev <= act_now;
    end

    always_comb begin
        trig.level = act_now;
        trig.fire  = act_now & ~act_prev & ~rst;
    end

    // R5: a transition lasts a single cycle; a held level does not repeat it
    a_r5_single_fire: assert property (@(posedge clk) disable iff (rst)
        trig.fire |=> !trig.fire);

    // R5: a transition only ever coincides with the active level
    a_r5_fire_needs_level: assert property (@(posedge clk) disable iff (rst)
        trig.fire |-> trig.level);
endmodule

// File: rtl/mrst_timer.sv
module mrst_timer #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;          // R8: restart from zero on any new edge
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;      // R6: ends regardless of pin level
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: a trigger arms the pulse with a cleared count
    a_r3_start_arms: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cnt == '0));

    // R6: the pulse ends once the count reaches its last value
    a_r6_ends_on_last: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cnt == LAST) |=> !busy);

    // R8: the pulse never ends early
    a_r8_no_early_end: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cnt != LAST) |=> busy);
endmodule

// File: rtl/mrst_pulse_gen.sv
module mrst_pulse_gen
    import mrst_pkg::*;
#(
    parameter int PULSE_CYCLES = 10_000_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_pin,
    input  logic pol_low,
    output logic rst_hi_o,
    output logic rst_lo_o,
    output logic mem_inhibit_o
);
    logic     pin_s;
    trig_t    trig;
    logic     busy;
    pin_pol_e pol;

    assign pol = pin_pol_e'(pol_low);

    mrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (mr_pin),
        .dout (pin_s)
    );

    mrst_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .sync_pin (pin_s),
        .pol      (pol),
        .trig     (trig)
    );

    mrst_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (trig.fire),
        .busy  (busy)
    );

    always_comb begin
        rst_hi_o      = rst | busy;
        rst_lo_o      = ~rst_hi_o;
        mem_inhibit_o = rst_hi_o | trig.level;
    end

    // R1: power-on reset forces the reset outputs active
    a_r1_por_active: assert property (@(posedge clk)
        rst |-> (rst_hi_o && !rst_lo_o && mem_inhibit_o));

    // R7: memory stays blocked whenever the reset pulse is active
    a_r7_inhibit_covers: assert property (@(posedge clk) disable iff (rst)
        rst_hi_o |-> mem_inhibit_o);

    // R9: the two reset outputs never agree
    a_r9_complement: assert property (@(posedge clk)
        rst_hi_o != rst_lo_o);
endmodule

// File: tb/sim_mrst_pulse_gen.sv
module sim_mrst_pulse_gen;
    localparam int P = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mr_pin = 1'b0;
    logic pol_low = 1'b0;
    logic rst_hi_o, rst_lo_o, mem_inhibit_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mrst_pulse_gen #(.PULSE_CYCLES(P)) u0 (
        .clk(clk), .rst(rst), .mr_pin(mr_pin), .pol_low(pol_low),
        .rst_hi_o(rst_hi_o), .rst_lo_o(rst_lo_o), .mem_inhibit_o(mem_inhibit_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // reset outputs plus the complement rule (R9)
    task automatic chk_rst(input string req, input logic exp);
        chk(req, "rst_hi_o", rst_hi_o, exp);
        chk("R9", "rst_lo_o", rst_lo_o, ~exp);
    endtask

    task automatic por(input logic pol, input logic pin);
        rst = 1'b1; pol_low = pol; mr_pin = pin;
        step(4);
        chk_rst("R1", 1'b1);
        chk("R1", "mem_inhibit_o", mem_inhibit_o, 1'b1);
        rst = 1'b0;
    endtask

    task automatic t_reset_release;
        por(1'b0, 1'b0);
        step(1);
        chk_rst("R2", 1'b0);
        chk("R2", "mem_inhibit_o", mem_inhibit_o, 1'b0);
        step(5);
        chk_rst("R2", 1'b0);
    endtask

    task automatic t_rising;
        mr_pin = 1'b1;
        step(1); chk_rst("R3", 1'b0); chk("R7", "inhibit n1", mem_inhibit_o, 1'b0);
        step(1); chk_rst("R3", 1'b0); chk("R7", "inhibit n2", mem_inhibit_o, 1'b1);
        step(1); chk_rst("R3", 1'b1);
        mr_pin = 1'b0;
        step(P - 1); chk_rst("R3", 1'b1);
        step(1); chk_rst("R3", 1'b0);
        chk("R7", "inhibit after pulse", mem_inhibit_o, 1'b0);
        step(4);
    endtask

    task automatic t_short;
        mr_pin = 1'b1;
        step(1); mr_pin = 1'b0;
        step(2); chk_rst("R10", 1'b1);
        step(P - 1); chk_rst("R10", 1'b1);
        step(1); chk_rst("R10", 1'b0);
        step(4);
    endtask

    task automatic t_hold;
        mr_pin = 1'b1;
        step(3); chk_rst("R6", 1'b1);
        step(P); chk_rst("R6", 1'b0);
        chk("R7", "inhibit while held", mem_inhibit_o, 1'b1);
        step(10); chk_rst("R5", 1'b0);
        mr_pin = 1'b0;
        step(1); chk("R7", "inhibit lag", mem_inhibit_o, 1'b1);
        step(1); chk("R7", "inhibit released", mem_inhibit_o, 1'b0);
        step(4); chk_rst("R5", 1'b0);
    endtask

    task automatic t_retrigger;
        mr_pin = 1'b1;
        step(3); chk_rst("R8", 1'b1);
        mr_pin = 1'b0;
        step(5);                       // n = 8: second active edge
        mr_pin = 1'b1;
        step(P - 5); chk_rst("R8", 1'b1);   // n = P+3: first pulse would be over
        mr_pin = 1'b0;
        step(7); chk_rst("R8", 1'b1);       // n = P+10
        step(1); chk_rst("R8", 1'b0);       // n = P+11
        step(4);
    endtask

    task automatic t_active_low;
        por(1'b1, 1'b1);
        step(3);
        chk_rst("R4", 1'b0);
        chk("R4", "inhibit idle", mem_inhibit_o, 1'b0);
        mr_pin = 1'b0;
        step(3); chk_rst("R4", 1'b1);
        step(P - 1); chk_rst("R4", 1'b1);
        step(1); chk_rst("R4", 1'b0);
        chk("R7", "inhibit low held", mem_inhibit_o, 1'b1);
        mr_pin = 1'b1;
        step(4); chk_rst("R5", 1'b0);
        chk("R7", "inhibit low released", mem_inhibit_o, 1'b0);
    endtask

    task automatic t_level_at_release;
        por(1'b0, 1'b1);
        step(1);
        chk_rst("R5", 1'b0);
        chk("R7", "inhibit held at release", mem_inhibit_o, 1'b1);
        step(P + 5); chk_rst("R5", 1'b0);
        mr_pin = 1'b0;
        step(3); chk("R7", "inhibit cleared", mem_inhibit_o, 1'b0);
        chk_rst("R5", 1'b0);
    endtask

    initial begin
        t_reset_release();
        t_rising();
        t_short();
        t_hold();
        t_retrigger();
        t_active_low();
        t_level_at_release();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule